// File: doc/BRIEF.md
# PLL Cycle Slip Detector

This block watches two clocks of a phase-locked loop: the reference clock and the divided output clock that returns as feedback. Both are treated as asynchronous inputs. Each is brought into a single fast system clock through a synchronizer, and its rising edges become one-cycle pulses. The two edge streams are then compared. If two feedback edges arrive with no reference edge between them, the output is running too fast, and a reference slip is raised. If two reference edges arrive with no feedback edge between them, the output is running too slow, and a feedback slip is raised.

Each slip direction has its own optional filter. When the filter is enabled, a slip is logged only after a programmed number of consecutive raw slip events of that kind. A clean comparison of that kind restarts the count.

Logged slips are held in two sticky status bits that software can read. Each bit is cleared by writing a one to it. The response to a logged slip belongs to logic outside this block. All pins are plain control and status signals, so there is no streaming interface and no back-pressure.

Top module: `pll_slip_det`

## Requirements
- R1: With the filter disabled, two reference rising edges with no feedback rising edge between them set `stat_fb_slip`.
- R2: With the filter disabled, two feedback rising edges with no reference rising edge between them set `stat_ref_slip`.
- R3: Strictly alternating edges, and edges of both clocks landing in the same system cycle, set neither status bit.
- R4: With `filt_en` high and `filt_cnt` = N (N from 1 to 15), a status bit is set only on the N-th consecutive raw slip of its kind. Fewer events leave it clear.
- R5: A clean comparison of a kind resets that kind's filter count. For the feedback filter this is a reference edge with a feedback edge seen since the previous reference edge. For the reference filter this is a feedback edge with a reference edge seen since the previous feedback edge.
- R6: With `filt_en` high and `filt_cnt` = 0, the filter behaves as N = 1.
- R7: Status bits stay set until a one is written to their clear input. Clearing one bit leaves the other unchanged.
- R8: A slip logged in the same cycle as its clear leaves the status bit set.
- R9: After reset both status bits read 0.
- R10: The first rising edge of each clock after reset only arms that clock's comparison and never by itself reports a slip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk_in | input | 1 | PLL reference clock (asynchronous) |
| fb_clk_in | input | 1 | Divided PLL output clock (asynchronous) |
| filt_en | input | 1 | Enable the consecutive-event filter |
| filt_cnt | input | CNT_W | Consecutive raw events required; 0 acts as 1 |
| clr_ref_slip | input | 1 | Write-one-to-clear for the reference slip bit |
| clr_fb_slip | input | 1 | Write-one-to-clear for the feedback slip bit |
| stat_ref_slip | output | 1 | Sticky flag: output ran too fast |
| stat_fb_slip | output | 1 | Sticky flag: output ran too slow |

## Verification
The comparator is driven with several kinds of edge sequence:
- Alternating edges and simultaneous edges tell a healthy loop apart from a slipping one.
- Repeated reference edges and repeated feedback edges check that each direction lands on its own flag.
- Runs one event short of the threshold and runs that reach it separate a filter that counts correctly from one off by one.
- A run broken by a single clean comparison shows whether the count restarts.

Directed sequences then cover the first edges after reset, clearing each flag on its own, and a clear that coincides with a new slip.

// File: rtl/slip_pkg.sv
package slip_pkg;
  localparam int KINDS  = 2;
  localparam int IDX_REF = 0; // output ran too fast
  localparam int IDX_FB  = 1; // output ran too slow
endpackage

// File: rtl/slip_edge_sync.sv
module slip_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], async_in};
      prev <= sh[STAGES-1];
    end
  end

  assign rise = sh[STAGES-1] & ~prev;

  // R3: an edge pulse never lasts two cycles, so one edge counts once
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/slip_compare.sv
module slip_compare
  import slip_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_e,
  input  logic             fb_e,
  output logic [KINDS-1:0] raw,
  output logic [KINDS-1:0] clean
);
  logic ref_armed, fb_armed;
  logic fb_since_ref, ref_since_fb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_armed    <= 1'b0;
      fb_armed     <= 1'b0;
      fb_since_ref <= 1'b0;
      ref_since_fb <= 1'b0;
    end else begin
      if (ref_e) ref_armed <= 1'b1;
      if (fb_e)  fb_armed  <= 1'b1;
      if (ref_e)     fb_since_ref <= fb_e;
      else if (fb_e) fb_since_ref <= 1'b1;
      if (fb_e)       ref_since_fb <= ref_e;
      else if (ref_e) ref_since_fb <= 1'b1;
    end
  end

  always_comb begin
    raw[IDX_FB]    = ref_e & ref_armed & ~fb_since_ref & ~fb_e;
    clean[IDX_FB]  = ref_e & ref_armed & (fb_since_ref | fb_e);
    raw[IDX_REF]   = fb_e & fb_armed & ~ref_since_fb & ~ref_e;
    clean[IDX_REF] = fb_e & fb_armed & (ref_since_fb | ref_e);
  end
endmodule

// File: rtl/slip_filter.sv
module slip_filter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] thr,
  input  logic             raw,
  input  logic             clean,
  output logic             fire
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   thr_eff;
  logic [CNT_W:0]   nxt;

  always_comb begin
    thr_eff = (thr == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, thr};
    nxt     = {1'b0, cnt} + 1'b1;
    fire    = raw & (~en | (nxt >= thr_eff));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!en)    cnt <= '0;
    else if (clean)  cnt <= '0;
    else if (raw)    cnt <= fire ? '0 : nxt[CNT_W-1:0];
  end

  // R4: the running count stays below the threshold it is compared against
  assert_cnt_below_thr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && thr == $past(thr)) |-> ({1'b0, cnt} < thr_eff));
  // R5: a clean comparison leaves the count at zero
  assert_clean_resets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clean |=> (cnt == '0));
endmodule

// File: rtl/pll_slip_det.sv
module pll_slip_det
  import slip_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_clk_in,
  input  logic             fb_clk_in,
  input  logic             filt_en,
  input  logic [CNT_W-1:0] filt_cnt,
  input  logic             clr_ref_slip,
  input  logic             clr_fb_slip,
  output logic             stat_ref_slip,
  output logic             stat_fb_slip
);
  logic             ref_e, fb_e;
  logic [KINDS-1:0] raw, clean, fire, clr, stat;

  slip_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_ref (
    .clk(clk), .rst_n(rst_n), .async_in(ref_clk_in), .rise(ref_e));
  slip_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_fb (
    .clk(clk), .rst_n(rst_n), .async_in(fb_clk_in), .rise(fb_e));

  slip_compare u_cmp (
    .clk(clk), .rst_n(rst_n), .ref_e(ref_e), .fb_e(fb_e),
    .raw(raw), .clean(clean));

  assign clr[IDX_REF] = clr_ref_slip;
  assign clr[IDX_FB]  = clr_fb_slip;

  for (genvar k = 0; k < KINDS; k++) begin : g_kind
    slip_filter #(.CNT_W(CNT_W)) u_filt (
      .clk(clk), .rst_n(rst_n), .en(filt_en), .thr(filt_cnt),
      .raw(raw[k]), .clean(clean[k]), .fire(fire[k]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat[k] <= 1'b0;
      else        stat[k] <= fire[k] | (stat[k] & ~clr[k]);
    end

    // R7: a logged slip holds until its own clear
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[k] && !clr[k]) |=> stat[k]);
    // R7: a clear with no new slip empties the bit
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[k] && !fire[k]) |=> !stat[k]);
    // R8: a slip beats a clear in the same cycle
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fire[k] |=> stat[k]);
  end

  assign stat_ref_slip = stat[IDX_REF];
  assign stat_fb_slip  = stat[IDX_FB];
endmodule

// File: tb/tb_pll_slip_det.sv
module tb_pll_slip_det;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_clk_in = 1'b0, fb_clk_in = 1'b0;
  logic filt_en = 1'b0;
  logic [3:0] filt_cnt = 4'd0;
  logic clr_ref_slip = 1'b0, clr_fb_slip = 1'b0;
  logic stat_ref_slip, stat_fb_slip;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk; // 125 MHz

  pll_slip_det dut (
    .clk(clk), .rst_n(rst_n), .ref_clk_in(ref_clk_in), .fb_clk_in(fb_clk_in),
    .filt_en(filt_en), .filt_cnt(filt_cnt), .clr_ref_slip(clr_ref_slip),
    .clr_fb_slip(clr_fb_slip), .stat_ref_slip(stat_ref_slip),
    .stat_fb_slip(stat_fb_slip));

  // {en, N[3:0], events[15:0], exp_ref, exp_fb}; event i in bits [2i+1:2i]
  // event codes: 01 reference edge, 10 feedback edge, 11 both, 00 idle
  localparam int NV = 12;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 4'd0,  16'h0999, 1'b0, 1'b0}, // R3 alternating
    {1'b0, 4'd0,  16'h0005, 1'b0, 1'b1}, // R1 R R
    {1'b0, 4'd0,  16'h000A, 1'b1, 1'b0}, // R2 F F
    {1'b1, 4'd3,  16'h0015, 1'b0, 1'b0}, // R4 two raw, N=3
    {1'b1, 4'd3,  16'h0055, 1'b0, 1'b1}, // R4 three raw, N=3
    {1'b1, 4'd3,  16'h0595, 1'b0, 1'b0}, // R5 R10 run broken by clean
    {1'b1, 4'd2,  16'h002A, 1'b1, 1'b0}, // R4 F F F, N=2
    {1'b1, 4'd0,  16'h0005, 1'b0, 1'b1}, // R6 N=0 acts as 1
    {1'b0, 4'd0,  16'h003F, 1'b0, 1'b0}, // R3 simultaneous edges
    {1'b0, 4'd0,  16'h0029, 1'b1, 1'b0}, // R10 R F F
    {1'b1, 4'd15, 16'h5555, 1'b0, 1'b0}, // R4 seven raw, N=15
    {1'b0, 4'd0,  16'h005A, 1'b1, 1'b1}  // R1 R2 both directions
  };

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual ref/fb=%b expected ref/fb=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ref_clk_in = 1'b0; fb_clk_in = 1'b0;
    clr_ref_slip = 1'b0; clr_fb_slip = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic ev(input logic [1:0] e);
    @(negedge clk);
    ref_clk_in = e[0];
    fb_clk_in  = e[1];
    repeat (4) @(negedge clk);
    ref_clk_in = 1'b0;
    fb_clk_in  = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R9: reset state
    do_reset();
    @(negedge clk);
    chk("R9 reset state", {stat_ref_slip, stat_fb_slip}, 2'b00);

    for (int v = 0; v < NV; v++) begin
      do_reset();
      filt_en  = VEC[v][22];
      filt_cnt = VEC[v][21:18];
      for (int i = 0; i < 8; i++) ev(VEC[v][2*i+2 +: 2]);
      repeat (6) @(negedge clk);
      chk($sformatf("vector %0d", v), {stat_ref_slip, stat_fb_slip}, VEC[v][1:0]);
    end

    // R7: clear each bit on its own
    do_reset();
    filt_en = 1'b0;
    ev(2'b10); ev(2'b10); ev(2'b01); ev(2'b01);
    repeat (4) @(negedge clk);
    chk("R7 both set before clear", {stat_ref_slip, stat_fb_slip}, 2'b11);
    clr_ref_slip = 1'b1;
    @(negedge clk);
    clr_ref_slip = 1'b0;
    @(negedge clk);
    chk("R7 clear ref keeps fb", {stat_ref_slip, stat_fb_slip}, 2'b01);
    repeat (5) @(negedge clk);
    chk("R7 stays after clear", {stat_ref_slip, stat_fb_slip}, 2'b01);
    clr_fb_slip = 1'b1;
    @(negedge clk);
    clr_fb_slip = 1'b0;
    @(negedge clk);
    chk("R7 clear fb", {stat_ref_slip, stat_fb_slip}, 2'b00);

    // R8: slip lands in the same cycle as its clear
    do_reset();
    filt_en = 1'b0;
    ev(2'b01);                 // arms reference comparison (R10)
    @(negedge clk);
    ref_clk_in = 1'b1;         // captured at edge k; status sets at edge k+2
    @(negedge clk);
    @(negedge clk);
    clr_fb_slip = 1'b1;        // active across edge k+2
    @(negedge clk);
    clr_fb_slip = 1'b0;
    chk("R8 slip wins over clear", {stat_ref_slip, stat_fb_slip}, 2'b01);
    repeat (3) @(negedge clk);
    ref_clk_in = 1'b0;
    repeat (4) @(negedge clk);

    // R10: one edge of each clock after reset reports nothing
    do_reset();
    ev(2'b10); ev(2'b01);
    repeat (4) @(negedge clk);
    chk("R10 first edges only arm", {stat_ref_slip, stat_fb_slip}, 2'b00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule